// File: doc/BRIEF.md
# SPI Chip-Select Mask Controller

Up to four write-only codec control ports share one SPI bus and one host slave-select line. This controller sits on that bus and watches every write frame. A frame whose first bit, bit 15 of the 16-bit word, is set is a private command that the codecs must never see. When such a frame is exactly 16 bits long, its four low bits are stored as a select mask. Any other frame is passed through: the host slave-select is fanned out only to the devices whose mask bit is set. The host can therefore address one codec or broadcast to several of them, using ordinary control writes.

The bus pins are oversampled by the system clock through a synchronizer. A deframer detects the slave-select edges, counts the SCLK rising edges and shifts in MOSI with the MSB first. A three-state machine decides at the start of each frame whether the frame is passed through or intercepted. A combinational gate with the raw slave-select makes sure that no device stays selected once the host deselects the bus. How mask bits map to board positions is set by the system. A two-codec board can use bits 0/1, bits 2/3 or bits 0/3, depending on how it is wired into the chain.

States and transitions. IDLE goes to PASS when the slave-select falls while MOSI is 0. IDLE goes to CAPT when the slave-select falls while MOSI is 1. PASS goes to IDLE when the slave-select rises. CAPT goes to IDLE when the slave-select rises, and the mask is loaded on that transition if the frame held exactly 16 bits.

Top module: `spi_csmask_ctrl`

## Requirements
- R1: After reset the mask is 0000, so no `dev_cs_n` line goes low during any frame until a valid mask command has been received.
- R2: While `spi_ss_n` is high, every `dev_cs_n` line is high, from the moment `spi_ss_n` rises and regardless of the mask.
- R3: During a frame whose first bit is 0, `dev_cs_n[i]` is low if and only if mask bit i is 1. The host presents the first bit on MOSI when it drives `spi_ss_n` low.
- R4: During a frame whose first bit is 1 (a mask command), all `dev_cs_n` lines stay high for the whole frame.
- R5: A mask command of exactly 16 bits (sent MSB first, sampled on SCLK rising edges, bit 15 = 1) loads mask bit i from word bit i for i = 0..3 when `spi_ss_n` rises. Word bits 14..4 are ignored.
- R6: A frame whose first bit is 1 but which holds a bit count other than 16 (fewer or more) leaves the mask unchanged.
- R7: A mask with several bits set selects all of those devices together during one following write (broadcast). A mask with one bit set selects only that device.
- R8: A newly loaded mask takes effect from the next frame and does not change the selects during the command frame that carried it.
- R9: A frame whose first bit is 0 never alters the mask, whatever its low bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Host SPI serial clock |
| spi_mosi | input | 1 | Host serial data, MSB first |
| spi_ss_n | input | 1 | Host slave-select, active low |
| dev_cs_n | output | 4 | Per-device chip-selects, active low, bit i gated by mask bit i |

## Verification
The bench samples the selects at the instant the host releases the slave-select. A design that relies only on the synchronized copy would leave a device selected there for a few clocks. It sends 15-bit and 17-bit command frames: a design that loads on any rising edge of the slave-select, or that counts modulo 16, would then pick up a false mask. It sends ordinary frames whose low nibble is all ones and command words with bits 14..4 set, which catches a design that loads from the wrong frame type or the wrong field. Broadcast, single-device and mid-run reset cases confirm the active-low polarity and that each mask bit goes to the right pin.

// File: rtl/spi_csm_pkg.sv
package spi_csm_pkg;

    localparam int CSM_WORD_W   = 16;
    localparam int CSM_NUM_DEV  = 4;
    localparam int CSM_SYNC_LEN = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_CAPT = 2'd2
    } csm_state_e;

endpackage

// File: rtl/spi_csm_sync.sv
module spi_csm_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[b]}};
                end else begin
                    chain <= {chain[STAGES-2:0], d[b]};
                end
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_csm_deframe.sv
module spi_csm_deframe #(
    parameter int WORD_W  = 16,
    parameter int NUM_DEV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ss_s,
    input  logic               sclk_s,
    input  logic               mosi_s,
    output logic               start_evt,
    output logic               end_evt,
    output logic               first_bit,
    output logic               frame_ok,
    output logic               cmd_flag,
    output logic [NUM_DEV-1:0] field
);

    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic              ss_d;
    logic              sclk_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic              sclk_rise;

    assign start_evt = ss_d & ~ss_s;
    assign end_evt   = ~ss_d & ss_s;
    assign sclk_rise = ~sclk_d & sclk_s & ~ss_s;
    assign first_bit = mosi_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            ss_d   <= ss_s;
            sclk_d <= sclk_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (start_evt) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (sclk_rise) begin
            shreg <= {shreg[WORD_W-2:0], mosi_s};
            if (bit_cnt != CNT_W'(CNT_MAX)) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    assign frame_ok = (bit_cnt == CNT_W'(WORD_W));
    assign cmd_flag = shreg[WORD_W-1];
    assign field    = shreg[NUM_DEV-1:0];

    // R6: the counter saturates above the word length, so a long frame never wraps to a valid count
    assert_count_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(CNT_MAX));

    // R6: the count restarts at every new frame
    assert_count_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (bit_cnt <= CNT_W'(1)));

endmodule

// File: rtl/spi_csm_fsm.sv
module spi_csm_fsm
    import spi_csm_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_evt,
    input  logic               end_evt,
    input  logic               first_bit,
    input  logic               frame_ok,
    input  logic               cmd_flag,
    input  logic [NUM_DEV-1:0] field,
    output logic [NUM_DEV-1:0] sel_n
);

    csm_state_e         state;
    csm_state_e         nxt;
    logic [NUM_DEV-1:0] mask;
    logic               load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start_evt) nxt = first_bit ? ST_CAPT : ST_PASS;
            ST_PASS: if (end_evt)   nxt = ST_IDLE;
            ST_CAPT: if (end_evt)   nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    assign load = (state == ST_CAPT) && end_evt && frame_ok && cmd_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (load) begin
            mask <= field;
        end
    end

    always_comb begin
        sel_n = '1;
        unique case (state)
            ST_PASS: sel_n = ~mask;
            ST_IDLE: sel_n = '1;
            ST_CAPT: sel_n = '1;
            default: sel_n = '1;
        endcase
    end

    // R3: a passed frame drives exactly the masked devices
    assert_pass_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS) |-> (sel_n == ~mask));

    // R4: nothing is selected while a command frame is on the bus
    assert_cmd_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPT) |-> (&sel_n));

    // R5: a full-length command loads the low field
    assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CAPT) && end_evt && frame_ok && cmd_flag) |=> (mask == $past(field)));

    // R6: a command of the wrong length leaves the mask alone
    assert_bad_len_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CAPT) && end_evt && !frame_ok) |=> $stable(mask));

    // R8: the mask does not move while the command frame is still open
    assert_mask_next_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CAPT) && !end_evt) |=> $stable(mask));

    // R9: ordinary frames never alter the mask
    assert_pass_keeps_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS) |=> $stable(mask));

endmodule

// File: rtl/spi_csmask_ctrl.sv
module spi_csmask_ctrl
    import spi_csm_pkg::*;
#(
    parameter int WORD_W   = CSM_WORD_W,
    parameter int NUM_DEV  = CSM_NUM_DEV,
    parameter int SYNC_LEN = CSM_SYNC_LEN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sclk,
    input  logic               spi_mosi,
    input  logic               spi_ss_n,
    output logic [NUM_DEV-1:0] dev_cs_n
);

    localparam int PIN_W = 3;

    logic [PIN_W-1:0]   pins_raw;
    logic [PIN_W-1:0]   pins_s;
    logic               start_evt;
    logic               end_evt;
    logic               first_bit;
    logic               frame_ok;
    logic               cmd_flag;
    logic [NUM_DEV-1:0] field;
    logic [NUM_DEV-1:0] sel_n;

    assign pins_raw = {spi_ss_n, spi_sclk, spi_mosi};

    spi_csm_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_LEN),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    spi_csm_deframe #(
        .WORD_W  (WORD_W),
        .NUM_DEV (NUM_DEV)
    ) u_deframe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_s      (pins_s[2]),
        .sclk_s    (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .start_evt (start_evt),
        .end_evt   (end_evt),
        .first_bit (first_bit),
        .frame_ok  (frame_ok),
        .cmd_flag  (cmd_flag),
        .field     (field)
    );

    spi_csm_fsm #(
        .NUM_DEV (NUM_DEV)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .end_evt   (end_evt),
        .first_bit (first_bit),
        .frame_ok  (frame_ok),
        .cmd_flag  (cmd_flag),
        .field     (field),
        .sel_n     (sel_n)
    );

    assign dev_cs_n = sel_n | {NUM_DEV{spi_ss_n}};

    // R2: a released host select releases every device
    assert_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_ss_n |-> (&dev_cs_n));

endmodule

// File: tb/spi_csmask_ctrl_test.sv
`timescale 1ns/1ps
module spi_csmask_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_ss_n = 1'b1;
    logic [3:0] dev_cs_n;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    logic [3:0] mdl_mask = 4'h0;
    logic [3:0] exp_q[$];
    string      tag_q[$];
    event       probe;

    always #10 clk = ~clk;

    spi_csmask_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sclk (spi_sclk),
        .spi_mosi (spi_mosi),
        .spi_ss_n (spi_ss_n),
        .dev_cs_n (dev_cs_n)
    );

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: dev_cs_n=%b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(probe);
            @(posedge clk);
            #5;
            check(dev_cs_n, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic push_probe(input logic [3:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        -> probe;
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input logic [31:0] w, input int nb, input string tag);
        logic       first;
        logic [3:0] exp;
        first = w[nb-1];
        exp   = first ? 4'hF : ~mdl_mask;
        @(negedge clk) spi_mosi = first;
        @(negedge clk) spi_ss_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = nb - 1; i >= 0; i--) begin
            spi_mosi = w[i];
            repeat (4) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (8) @(negedge clk);
            spi_sclk = 1'b0;
            repeat (4) @(negedge clk);
            if (i == nb - 8) push_probe(exp, tag);
        end
        spi_ss_n = 1'b1;
        push_probe(4'hF, "R2");
        repeat (12) @(negedge clk);
        push_probe(4'hF, "R2");
        if (nb == 16 && w[15]) mdl_mask = w[3:0];
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(dev_cs_n, 4'hF, "R1");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(dev_cs_n, 4'hF, "R1");
        frame(32'h1234, 16, "R1");

        frame(32'h8005, 16, "R4");
        frame(32'h0A0F, 16, "R8");
        frame(32'h0000, 16, "R3");

        frame(32'h800F, 16, "R8");
        frame(32'h0123, 16, "R7");

        frame(32'h8002, 16, "R4");
        frame(32'h0456, 16, "R7");

        frame(32'h4008, 15, "R4");
        frame(32'h0789, 16, "R6");
        frame(32'h10004, 17, "R4");
        frame(32'h0ABC, 16, "R6");

        frame(32'hFFF8, 16, "R5");
        frame(32'h7FFF, 16, "R5");
        frame(32'h0001, 16, "R9");
        frame(32'h0FF, 12, "R3");
        frame(32'h0002, 16, "R9");

        @(negedge clk) rst_n = 1'b0;
        mdl_mask = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        frame(32'h0333, 16, "R1");
        frame(32'h8009, 16, "R4");
        frame(32'h0444, 16, "R3");

        repeat (10) @(negedge clk);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule